// File: doc/BRIEF.md
# Pixel Arrival-Time and Pulse-Width Digitizer

This block is the digital back end of a single pixel in a hybrid pixel readout chip. It watches the pixel's discriminator output, which is asynchronous to the chip, and runs on the bunch-crossing clock. For each pulse it records two values from the same event. The first is the arrival time, a 12-bit tag taken from a free-running bunch counter. The second is the pulse width, a 4-bit time-over-threshold count in bunch periods.

There is no acquisition window. The pixel is always armed, and it only speaks when it has been hit. A finished measurement sits in a one-entry output register and is offered through a valid/ready handshake until the downstream logic takes it. A pulse whose leading edge arrives while that register is occupied is not measured. It is tallied in a saturating lost-hit counter instead.

Top module: `pix_tot_digitizer`

## Requirements
- R1: After reset, `hit_valid` is 0, `lost_hits` is 0 and the bunch counter is 0. A pulse driven high in the first cycle after reset is released therefore carries arrival time 2.
- R2: The bunch counter advances by one on every clock edge out of reset and wraps from 4095 to 0 without a gap. This is seen in the arrival times 4095 and 0 of pulses started at counter values 4093 and 4094.
- R3: The arrival time `hit_toa` equals the bunch counter value in the cycle `disc_in` went high, plus 2, modulo 4096. The 2 is the synchronizer depth.
- R4: For a pulse that lasts W whole clock cycles, with 1 <= W <= 14, `hit_tot` equals W. `hit_valid` rises W+3 clock edges after the rising input is applied.
- R5: For W >= 15, `hit_tot` is 15, the saturated value. The record appears 18 edges after the rising input, even while the input is still high. Exactly one record is produced per pulse, however long the pulse lasts.
- R6: While `hit_valid` is 1 and `hit_ready` is 0, `hit_toa` and `hit_tot` hold their values. A cycle with both `hit_valid` and `hit_ready` at 1 empties the register.
- R7: A rising input seen while the register is full and not being accepted adds 1 to `lost_hits` and produces no record. The counter saturates at 255.
- R8: With `disc_in` held low, `hit_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| disc_in | input | 1 | Discriminator output, asynchronous |
| hit_ready | input | 1 | Downstream accepts the offered record |
| hit_valid | output | 1 | A completed record is offered |
| hit_toa | output | 12 | Arrival time as a bunch-counter tag |
| hit_tot | output | 4 | Time over threshold in clock periods, saturating at 15 |
| lost_hits | output | 8 | Saturating count of pulses lost to a full register |

## Verification
The properties assume that `hit_ready` is a well-behaved handshake input. They also assume that the discriminator never produces a pulse, or a gap between pulses, shorter than one clock period. A sub-cycle glitch could fall between synchronizer samples and would have no defined width. The stimulus always changes `disc_in` on the falling clock edge, holds each level for at least one whole cycle, and raises `hit_ready` for single whole cycles. As a result, every pulse and every gap is seen by the synchronizer with a known width.

// File: rtl/pixfe_pkg.sv
package pixfe_pkg;

    localparam int TOA_W = 12;
    localparam int TOT_W = 4;

    typedef struct packed {
        logic [TOA_W-1:0] toa;
        logic [TOT_W-1:0] tot;
    } hit_rec_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_MEAS     = 2'd1,
        ST_WAIT_LOW = 2'd2
    } meas_state_t;

    function automatic logic [TOT_W-1:0] tot_limit();
        return {TOT_W{1'b1}};
    endfunction

endpackage

// File: rtl/pixfe_sync.sv
module pixfe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/pixfe_bxcnt.sv
module pixfe_bxcnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] bx
);
    always_ff @(posedge clk) begin
        if (rst) bx <= '0;
        else     bx <= bx + 1'b1;
    end
endmodule

// File: rtl/pixfe_meas.sv
module pixfe_meas
    import pixfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             fall,
    input  logic             level,
    input  logic             out_free,
    input  logic [TOA_W-1:0] bx,
    output logic             done,
    output logic             lost_evt,
    output hit_rec_t         rec
);
    meas_state_t      st;
    logic [TOA_W-1:0] toa_q;
    logic [TOT_W-1:0] cnt;
    logic             at_cap;

    assign at_cap   = (cnt == tot_limit());
    assign done     = (st == ST_MEAS) && (fall || at_cap);
    assign lost_evt = (st == ST_IDLE) && rise && !out_free;
    assign rec      = '{toa: toa_q, tot: cnt};

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            toa_q <= '0;
            cnt   <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (rise && out_free) begin
                        st    <= ST_MEAS;
                        toa_q <= bx;
                        cnt   <= TOT_W'(1);
                    end
                end
                ST_MEAS: begin
                    if (fall)        st  <= ST_IDLE;
                    else if (at_cap) st  <= ST_WAIT_LOW;
                    else             cnt <= cnt + 1'b1;
                end
                ST_WAIT_LOW: begin
                    if (!level) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pixfe_outreg.sv
module pixfe_outreg
    import pixfe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  hit_rec_t rec_in,
    input  logic     ready,
    output logic     valid,
    output logic     free,
    output hit_rec_t rec_out
);
    assign free = !valid || ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            rec_out <= '0;
        end else if (load) begin
            valid   <= 1'b1;
            rec_out <= rec_in;
        end else if (ready) begin
            valid   <= 1'b0;
        end
    end
endmodule

// File: rtl/pix_tot_digitizer.sv
module pix_tot_digitizer
    import pixfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOST_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disc_in,
    input  logic              hit_ready,
    output logic              hit_valid,
    output logic [TOA_W-1:0]  hit_toa,
    output logic [TOT_W-1:0]  hit_tot,
    output logic [LOST_W-1:0] lost_hits
);
    localparam logic [LOST_W-1:0] LOST_MAX = {LOST_W{1'b1}};

    logic             lvl, rise, fall;
    logic [TOA_W-1:0] bx_now;
    logic             meas_done, lost_evt, out_free;
    hit_rec_t         meas_rec, held_rec;

    pixfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(disc_in),
        .level(lvl), .rise(rise), .fall(fall)
    );

    pixfe_bxcnt #(.W(TOA_W)) u_bx (
        .clk(clk), .rst(rst), .bx(bx_now)
    );

    pixfe_meas u_meas (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall), .level(lvl),
        .out_free(out_free), .bx(bx_now),
        .done(meas_done), .lost_evt(lost_evt), .rec(meas_rec)
    );

    pixfe_outreg u_out (
        .clk(clk), .rst(rst), .load(meas_done), .rec_in(meas_rec),
        .ready(hit_ready), .valid(hit_valid), .free(out_free),
        .rec_out(held_rec)
    );

    always_ff @(posedge clk) begin
        if (rst)                                 lost_hits <= '0;
        else if (lost_evt && lost_hits != LOST_MAX) lost_hits <= lost_hits + 1'b1;
    end

    assign hit_toa = held_rec.toa;
    assign hit_tot = held_rec.tot;
endmodule

// File: rtl/pixfe_checker.sv
module pixfe_checker #(
    parameter int TW = 12,
    parameter int NW = 4,
    parameter int LW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          hit_valid,
    input logic          hit_ready,
    input logic [TW-1:0] hit_toa,
    input logic [NW-1:0] hit_tot,
    input logic [LW-1:0] lost_hits,
    input logic [TW-1:0] bx_now,
    input logic          meas_done
);
    p_bx_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> bx_now == TW'($past(bx_now) + 1'b1));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        hit_valid && !hit_ready |=> hit_valid && $stable(hit_toa) && $stable(hit_tot));

    p_drain_r6: assert property (@(posedge clk) disable iff (rst)
        hit_valid && hit_ready && !meas_done |=> !hit_valid);

    p_tot_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> hit_tot != '0);

    p_lost_step_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> lost_hits == $past(lost_hits) || lost_hits == LW'($past(lost_hits) + 1'b1));
endmodule

bind pix_tot_digitizer pixfe_checker #(
    .TW(pixfe_pkg::TOA_W), .NW(pixfe_pkg::TOT_W), .LW(LOST_W)
) u_chk (
    .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .hit_toa(hit_toa), .hit_tot(hit_tot), .lost_hits(lost_hits),
    .bx_now(bx_now), .meas_done(meas_done)
);

// File: tb/sim_pix_tot_digitizer.sv
`timescale 1ns/1ps
module sim_pix_tot_digitizer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        disc_in = 1'b0;
    logic        hit_ready = 1'b0;
    logic        hit_valid;
    logic [11:0] hit_toa;
    logic [3:0]  hit_tot;
    logic [7:0]  lost_hits;

    int n_cmp = 0;
    int n_bad = 0;
    logic [11:0] tb_bx = '0;

    always #2.5 clk = ~clk;

    // model of the bunch counter from R2
    always @(posedge clk) tb_bx <= rst ? 12'd0 : tb_bx + 12'd1;

    pix_tot_digitizer u0 (
        .clk(clk), .rst(rst), .disc_in(disc_in), .hit_ready(hit_ready),
        .hit_valid(hit_valid), .hit_toa(hit_toa), .hit_tot(hit_tot),
        .lost_hits(lost_hits)
    );

    localparam int NV = 9;
    localparam int VEC_W[NV] = '{1, 2, 3, 5, 8, 14, 15, 16, 30};
    localparam int VEC_T[NV] = '{1, 2, 3, 5, 8, 14, 15, 15, 15};

    task automatic chk(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic accept();
        hit_ready = 1'b1;
        tick(1);
        hit_ready = 1'b0;
    endtask

    // Pulse of width w, starting on the current negedge; register assumed empty.
    task automatic measure(input int w, input int exp_tot, input string req);
        int b, edge_at, total;
        logic seen_early;
        seen_early = 1'b0;
        b = int'(tb_bx);
        edge_at = 3 + ((w < 15) ? w : 15);
        total = ((edge_at > w) ? edge_at : w) + 4;
        disc_in = 1'b1;
        for (int n = 1; n <= total; n++) begin
            tick(1);
            if (n == w) disc_in = 1'b0;
            if (n == edge_at - 1 && hit_valid) seen_early = 1'b1;
            if (n == edge_at) begin
                chk({req, " valid timing"}, int'(hit_valid), 1);
                chk({req, " tot"}, int'(hit_tot), exp_tot);
                chk({req, " toa (R3)"}, int'(hit_toa), (b + 2) % 4096);
            end
        end
        chk({req, " not early"}, int'(seen_early), 0);
        chk({req, " single record"}, int'(hit_valid), 1);
        accept();
        chk({req, " drained (R6)"}, int'(hit_valid), 0);
        tick(2);
    endtask

    task automatic short_pulse(input int w);
        disc_in = 1'b1;
        tick(w);
        disc_in = 1'b0;
        tick(w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int toa_a;
        tick(3);
        // R1: reset state, counter starts at 0
        chk("R1 valid", int'(hit_valid), 0);
        chk("R1 lost", int'(lost_hits), 0);
        rst = 1'b0;
        disc_in = 1'b1;
        tick(3);
        disc_in = 1'b0;
        tick(3);
        chk("R1 first toa", int'(hit_toa), 2);
        chk("R1 first valid", int'(hit_valid), 1);
        accept();
        tick(2);

        // R8: no output without hits
        begin
            int bad = 0;
            for (int i = 0; i < 50; i++) begin
                tick(1);
                if (hit_valid) bad++;
            end
            chk("R8 idle valid", bad, 0);
        end

        // R4 / R5 from vector table
        for (int i = 0; i < NV; i++)
            measure(VEC_W[i], VEC_T[i], (VEC_W[i] < 15) ? "R4" : "R5");

        // R2: wrap of the bunch counter
        while (tb_bx != 12'd4093) tick(1);
        measure(2, 2, "R2 wrap 4095");
        while (tb_bx != 12'd4094) tick(1);
        measure(3, 3, "R2 wrap 0");

        // R7 / R6: pulse lost while register full
        toa_a = (int'(tb_bx) + 2) % 4096;
        short_pulse(4);
        tick(2);
        chk("R6 held valid", int'(hit_valid), 1);
        short_pulse(3);
        tick(4);
        chk("R7 lost count", int'(lost_hits), 1);
        chk("R6 held toa", int'(hit_toa), toa_a);
        chk("R6 held tot", int'(hit_tot), 4);
        accept();
        chk("R6 emptied", int'(hit_valid), 0);
        tick(1);
        measure(6, 6, "R7 after drain");
        chk("R7 count kept", int'(lost_hits), 1);

        // R7 saturation
        short_pulse(2);
        tick(3);
        for (int i = 0; i < 260; i++) short_pulse(2);
        tick(4);
        chk("R7 saturation", int'(lost_hits), 255);
        chk("R7 still held", int'(hit_valid), 1);

        // R1 reset in mid operation
        rst = 1'b1;
        tick(2);
        chk("R1 reset valid", int'(hit_valid), 0);
        chk("R1 reset lost", int'(lost_hits), 0);
        rst = 1'b0;
        tick(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule